// File: doc/BRIEF.md
# DMA Completion Event Counter and Interrupt

This block keeps the completion bookkeeping for one DMA channel. Every time the channel's engine loads a command list or finishes a command, it raises a single-cycle event pulse. The block counts these pulses in a wrapping 6-bit done counter. Software acknowledges work by writing a 6-bit processed counter into the same register. Software finds the number of unhandled events as the modular difference (done − processed) mod 64.

An interrupt-active flag is set on every event. Software clears it by writing the count register with that bit at 0. A small configuration register holds a master interrupt enable, a list-event interrupt enable and a level/pulse select. In level mode the interrupt stays high while the flag is set and both enables are on. In pulse mode it fires for one cycle per event. The counter never loses an event that arrives in the same cycle as a software write.

Top module: `dma_evt_irq`

## Requirements
- R1: After reset the count register, the configuration register and the interrupt output are all 0.
- R2: The done count (count register bits 5:0) increases by one on the clock edge after each event pulse and wraps from 63 to 0.
- R3: A software write to the count register never changes bits 5:0. An event in the same cycle as such a write is still counted.
- R4: A write to the count register (byte offset 0x18) loads bits 21:16 into the processed count. The processed count holds its value at all other times.
- R5: The interrupt-active flag (count register bit 8) is set by every event. A count-register write with bit 8 at 0 clears it, and a write with bit 8 at 1 leaves it unchanged.
- R6: When an event and a clearing write fall in the same cycle, the interrupt-active flag ends up set.
- R7: The configuration register sits at byte offset 0x00. Bit 31 is the list-event interrupt enable, bit 29 the master interrupt enable and bit 28 selects level mode (1) or pulse mode (0). All other bits read 0.
- R8: In level mode the interrupt output is high exactly while the interrupt-active flag, bit 29 and bit 31 are all set. It follows them in the same cycle as their register state.
- R9: In pulse mode the interrupt output is high for exactly the one cycle after an event that arrived while both enables were set, and low otherwise.
- R10: Writes to any offset other than 0x00 and 0x18 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data of the addressed register |
| evtPulse | input | 1 | One-cycle list-load or command-completion event |
| irqOut | output | 1 | Channel interrupt |

## Verification
The assertions check on every cycle the counter behaviour: the done count steps by exactly one per event and holds otherwise, and the processed count moves only on a count-register write. They also check that the flag is always set after an event, that a level interrupt is never high with the flag clear, and that a pulse interrupt only follows an event. Only the bench scenarios can show the rest. These are the wrap at 64, that bits 5:0 ignore software, the event-versus-clear collision, the read-back layout of both registers, the effect of each enable bit, and the silence of unmapped offsets. The bench checks all of these against a reference model under random traffic.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  // Byte offsets inside the channel window
  localparam int CFG_OFS = 'h00;
  localparam int CNT_OFS = 'h18;

  // Count register field positions (software depends on these)
  localparam int DONE_LSB = 0;
  localparam int ACT_BIT  = 8;
  localparam int PROC_LSB = 16;

  // Configuration register bit positions
  localparam int CFG_LVL_BIT  = 28;
  localparam int CFG_IEN_BIT  = 29;
  localparam int CFG_LIEN_BIT = 31;

  typedef struct packed {
    logic cfgWr;
    logic cntWr;
    logic ackClr;
    logic evt;
  } evtStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_CNT  = 2'd2
  } rdSel_e;

endpackage

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
  import dma_evt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              ackBit,
  input  logic              evtPulse,
  input  logic              actFlag,
  input  logic              cfgIen,
  input  logic              cfgLien,
  input  logic              cfgLvl,
  output evtStrobe_t        strb,
  output rdSel_e            rdSel,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] CfgAddr = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] CntAddr = ADDR_W'(CNT_OFS);

  logic hitCfg;
  logic hitCnt;
  logic irqEn;
  logic pulseQ;

  assign hitCfg = (regAddr == CfgAddr);
  assign hitCnt = (regAddr == CntAddr);

  always_comb begin
    strb.cfgWr  = regWrEn & hitCfg;
    strb.cntWr  = regWrEn & hitCnt;
    strb.ackClr = regWrEn & hitCnt & ~ackBit;
    strb.evt    = evtPulse;
  end

  always_comb begin
    if (hitCnt)      rdSel = RD_CNT;
    else if (hitCfg) rdSel = RD_CFG;
    else             rdSel = RD_NONE;
  end

  assign irqEn = cfgIen & cfgLien;

  // Pulse mode: one cycle per event taken while enabled
  always_ff @(posedge clk) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= evtPulse & irqEn;
  end

  assign irqOut = cfgLvl ? (actFlag & irqEn) : pulseQ;

  // R8: a level interrupt never stands without the active flag
  a_r8_level_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLvl && !actFlag) |-> !irqOut);

  // R9: a pulse interrupt only ever follows an event
  a_r9_pulse_after_event: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLvl && irqOut) |-> $past(evtPulse));

endmodule

// File: rtl/dma_evt_datapath.sv
module dma_evt_datapath
  import dma_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              actFlag,
  output logic              cfgIen,
  output logic              cfgLien,
  output logic              cfgLvl
);

  logic [CNT_W-1:0] doneCnt;
  logic [CNT_W-1:0] procCnt;
  logic             unusedWrBits;

  assign unusedWrBits = ^wrData;

  // Configuration bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgIen  <= 1'b0;
      cfgLien <= 1'b0;
      cfgLvl  <= 1'b0;
    end else if (strb.cfgWr) begin
      cfgIen  <= wrData[CFG_IEN_BIT];
      cfgLien <= wrData[CFG_LIEN_BIT];
      cfgLvl  <= wrData[CFG_LVL_BIT];
    end
  end

  // Done count: hardware only, never touched by software writes
  always_ff @(posedge clk) begin
    if (!rstN)         doneCnt <= '0;
    else if (strb.evt) doneCnt <= doneCnt + CNT_W'(1);
  end

  // Processed count: software only
  always_ff @(posedge clk) begin
    if (!rstN)           procCnt <= '0;
    else if (strb.cntWr) procCnt <= wrData[PROC_LSB +: CNT_W];
  end

  // Active flag: an event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)            actFlag <= 1'b0;
    else if (strb.evt)    actFlag <= 1'b1;
    else if (strb.ackClr) actFlag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_CNT: begin
        rdData[DONE_LSB +: CNT_W] = doneCnt;
        rdData[PROC_LSB +: CNT_W] = procCnt;
        rdData[ACT_BIT]           = actFlag;
      end
      RD_CFG: begin
        rdData[CFG_IEN_BIT]  = cfgIen;
        rdData[CFG_LIEN_BIT] = cfgLien;
        rdData[CFG_LVL_BIT]  = cfgLvl;
      end
      default: rdData = '0;
    endcase
  end

  // R2: each event advances the done count by exactly one
  a_r2_done_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.evt |=> (doneCnt == CNT_W'($past(doneCnt) + CNT_W'(1))));

  // R3: without an event the done count holds, whatever software writes
  a_r3_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evt |=> $stable(doneCnt));

  // R4: the processed count moves only on a count-register write
  a_r4_proc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntWr |=> $stable(procCnt));

  // R5 / R6: the flag is set after every event, even against a clear
  a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    strb.evt |=> actFlag);

endmodule

// File: rtl/dma_evt_irq.sv
module dma_evt_irq
  import dma_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtPulse,
  output logic              irqOut
);

  evtStrobe_t strb;
  rdSel_e     rdSel;
  logic       actFlag;
  logic       cfgIen;
  logic       cfgLien;
  logic       cfgLvl;

  dma_evt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .ackBit   (regWrData[ACT_BIT]),
    .evtPulse (evtPulse),
    .actFlag  (actFlag),
    .cfgIen   (cfgIen),
    .cfgLien  (cfgLien),
    .cfgLvl   (cfgLvl),
    .strb     (strb),
    .rdSel    (rdSel),
    .irqOut   (irqOut)
  );

  dma_evt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .actFlag (actFlag),
    .cfgIen  (cfgIen),
    .cfgLien (cfgLien),
    .cfgLvl  (cfgLvl)
  );

endmodule

// File: tb/dma_evt_irq_tb.sv
module dma_evt_irq_tb_top;

  localparam logic [7:0] A_CFG = 8'h00;
  localparam logic [7:0] A_CNT = 8'h18;
  localparam logic [7:0] A_OTH = 8'h04;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        evtPulse;
  logic        irqOut;

  always #2 clk = ~clk;

  dma_evt_irq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .evtPulse  (evtPulse),
    .irqOut    (irqOut)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state
  logic [5:0] mDone, mProc;
  logic       mFlag, mIen, mLien, mLvl, mPulse;

  function automatic logic [31:0] expRead(logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == A_CNT) begin
      v[5:0]   = mDone;
      v[21:16] = mProc;
      v[8]     = mFlag;
    end else if (a == A_CFG) begin
      v[31] = mLien;
      v[29] = mIen;
      v[28] = mLvl;
    end
    return v;
  endfunction

  function automatic logic expIrq();
    return mLvl ? (mFlag & mIen & mLien) : mPulse;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock with the given stimulus, then compare against the model
  task automatic step(logic e, logic w, logic [7:0] a, logic [31:0] d);
    logic oldEn;
    evtPulse  = e;
    regWrEn   = w;
    regAddr   = a;
    regWrData = d;
    @(posedge clk);
    #1;
    oldEn = mIen & mLien;
    if (w && a == A_CFG) begin
      mLien = d[31];
      mIen  = d[29];
      mLvl  = d[28];
    end
    if (e) mDone = mDone + 6'd1;
    if (w && a == A_CNT) mProc = d[21:16];
    if (e) mFlag = 1'b1;
    else if (w && a == A_CNT && !d[8]) mFlag = 1'b0;
    mPulse = e & oldEn;
    evtPulse = 1'b0;
    regWrEn  = 1'b0;
    if (a == A_CNT)      chk("R2 R3 R4 R5 R6 count register", regRdData, expRead(a));
    else if (a == A_CFG) chk("R7 config register", regRdData, expRead(a));
    else                 chk("R10 unmapped offset", regRdData, 32'h0);
    chk(mLvl ? "R8 level irq" : "R9 pulse irq", {31'b0, irqOut}, {31'b0, expIrq()});
  endtask

  task automatic readAt(logic [7:0] a, string tag);
    regAddr = a;
    #1;
    chk(tag, regRdData, expRead(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rstN = 1'b0; evtPulse = 1'b0; regWrEn = 1'b0; regAddr = A_CNT; regWrData = '0;
    mDone = '0; mProc = '0; mFlag = 0; mIen = 0; mLien = 0; mLvl = 0; mPulse = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    readAt(A_CNT, "R1 count after reset");
    readAt(A_CFG, "R1 config after reset");
    chk("R1 irq after reset", {31'b0, irqOut}, 32'h0);

    // R7 only three config bits stick
    step(0, 1, A_CFG, 32'hFFFF_FFFF);
    chk("R7 config readback", regRdData, 32'hB000_0000);

    // R2 wrap after 64 events
    for (int i = 0; i < 64; i++) step(1, 0, A_CNT, 32'h0);
    chk("R2 done wraps to 0", {26'b0, regRdData[5:0]}, 32'h0);

    // R3 write to done field ignored, coincident event counted
    step(0, 1, A_CNT, 32'h0000_013F);
    chk("R3 done ignores write", {26'b0, regRdData[5:0]}, 32'h0);
    step(1, 1, A_CNT, 32'h0025_013F);
    chk("R3 event with write", {26'b0, regRdData[5:0]}, 32'h1);
    chk("R4 processed loaded", {26'b0, regRdData[21:16]}, 32'h25);

    // R5 clear, then write with bit 8 high keeps state
    step(0, 1, A_CNT, 32'h0001_0000);
    chk("R5 flag cleared", {31'b0, regRdData[8]}, 32'h0);
    step(1, 0, A_CNT, 32'h0);
    step(0, 1, A_CNT, 32'h0002_0100);
    chk("R5 bit8 high keeps flag", {31'b0, regRdData[8]}, 32'h1);

    // R6 event and clear together
    step(1, 1, A_CNT, 32'h0003_0000);
    chk("R6 event beats clear", {31'b0, regRdData[8]}, 32'h1);

    // R10 unmapped write
    step(0, 1, A_OTH, 32'hFFFF_FFFF);
    readAt(A_CNT, "R10 count unchanged");
    readAt(A_CFG, "R10 config unchanged");

    // R9 pulse mode
    step(0, 1, A_CFG, 32'hA000_0000);
    step(1, 0, A_CNT, 32'h0);
    chk("R9 pulse high", {31'b0, irqOut}, 32'h1);
    step(0, 0, A_CNT, 32'h0);
    chk("R9 pulse one cycle", {31'b0, irqOut}, 32'h0);

    // R8 level mode
    step(0, 1, A_CFG, 32'hB000_0000);
    chk("R8 level high with flag", {31'b0, irqOut}, 32'h1);
    step(0, 1, A_CNT, 32'h0000_0000);
    chk("R8 level drops on clear", {31'b0, irqOut}, 32'h0);
    step(1, 1, A_CFG, 32'h9000_0000);
    chk("R8 no irq without master enable", {31'b0, irqOut}, 32'h0);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 6) ? A_CNT : (r < 9) ? A_CFG : A_OTH;
      d = $urandom;
      if (a == A_CFG && $urandom_range(0, 3) != 0) d[31] = 1'b1;
      if (a == A_CFG && $urandom_range(0, 3) != 0) d[29] = 1'b1;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, a, d);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule